// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer with a small bank of 16-bit registers. Software programs a timeout in half-second steps, arms the timer with a sticky run bit, and must then prove it is alive by writing a two-word key pair to a service word before the count runs out. The counter is paced by a slow 2 Hz tick-enable input rather than by the bus clock. When the count expires, the block raises a reset request for a fixed number of clock cycles. Depending on a sticky routing bit, that request goes either to an internal request line or to an active-low external reset pin.

An interrupt can be raised a chosen number of ticks before expiry. With a lead of zero, the interrupt fires in the same cycle as the reset. A second, simpler boot watchdog is running as soon as reset is released. It forces a reset every 16 seconds until software clears its enable. Once cleared, it cannot be turned back on.

Word addresses: 0 is control, 1 is service, 2 is interrupt control, 3 is boot control.

Top module: `kwdt_top`

## Requirements
- R1: After reset, the registers read as follows: control reads 0xFF00, interrupt control reads 0x0000, and boot control reads 0x0001. The outputs are idle: sys_rst_req=0, ext_rst_n=1 and irq=0.
- R2: Control bit 0 (run) and control bit 1 (route to external pin) can only be set. Once either bit is 1, writing 0 to it leaves it at 1, and a running timer keeps counting.
- R3: Setting run loads the counter with code+1 ticks, where code is control bits 15:8 (code = 2T-1 for a timeout of T seconds). Each tick then decrements the counter. The tick that would take it to zero is the expiry: it starts a reset pulse and reloads code+1.
- R4: Writing 0x5555 and then 0xAAAA to word 1 reloads the counter with code+1. Any write between the two keys cancels the pair, whether it is a different value or a write to another word. A lone 0xAAAA does nothing.
- R5: A new timeout code does not change a count already in progress. It applies from the next reload (service or expiry).
- R6: On expiry with bit 1 clear, sys_rst_req is high for exactly RST_CYCLES (default 8) clock cycles. With bit 1 set, ext_rst_n is low for the same time instead, and sys_rst_req stays 0.
- R7: Interrupt control works as follows. Bit 0 enables the interrupt, and bits 15:8 hold the lead in ticks. Bit 1 reads as the pending flag. The flag sets when, with bit 0 set, a tick leaves the count equal to the lead; expiry counts as zero. irq equals the pending flag, and writing 1 to bit 1 clears it.
- R8: Boot control bit 0 is 1 after reset. While it is 1, every BOOT_TICKS-th tick (default 32, i.e. 16 s) starts the same reset pulse as R6. Writing 0 clears the bit for good; writing 1 afterwards has no effect.
- R9: The service word always reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_2hz | input | 1 | One-cycle pulse at 2 Hz pacing both counters |
| bus_wr | input | 1 | Write strobe for one 16-bit word |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed word |
| sys_rst_req | output | 1 | Internal reset request pulse |
| ext_rst_n | output | 1 | External active-low reset pin |
| irq | output | 1 | Pre-timeout interrupt |

## Verification
Servicing is tried with three key patterns: the clean pair, a pair broken by a foreign value, and a pair broken by a write to another word. Only the clean pair may postpone expiry by a full period. The tick count before expiry is probed one tick short of and exactly at code+1, under two different codes, which separates reload from decrement off-by-one errors and shows whether a code change is applied late or at once. Expiry is repeated with each reset route and with interrupt leads of zero and one, which tells the two output paths apart and shows whether the interrupt fires with the reset or ahead of it.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_SVC  = 2'd1,
    REG_IRQC = 2'd2,
    REG_BOOT = 2'd3
  } kwdt_reg_e;

  localparam logic [15:0] KEY_FIRST  = 16'h5555;
  localparam logic [15:0] KEY_SECOND = 16'hAAAA;
  localparam int unsigned FIELD_LSB  = 8;
endpackage

// File: rtl/kwdt_keychk.sv
module kwdt_keychk #(
  parameter logic [15:0] KEY_A = 16'h5555,
  parameter logic [15:0] KEY_B = 16'hAAAA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic        is_svc,
  input  logic [15:0] wdata,
  output logic        svc_pulse
);
  logic armed_q, armed_d;

  // any write other than the first key disarms; the completing write also disarms
  always_comb begin
    armed_d = armed_q;
    if (wr) armed_d = is_svc && (wdata == KEY_A);
  end

  assign svc_pulse = wr && is_svc && armed_q && (wdata == KEY_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end
endmodule

// File: rtl/kwdt_downcnt.sv
module kwdt_downcnt #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] lead,
  output logic             expire,
  output logic             lead_hit,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d, remain;
  logic             dec;

  assign dec      = tick && run;
  assign remain   = cnt_q - CNT_W'(1);
  assign expire   = dec && (cnt_q <= CNT_W'(1));
  assign lead_hit = dec && (expire ? (lead == '0) : (remain == lead));

  always_comb begin
    cnt_d = cnt_q;
    if (load || expire) cnt_d = load_val;
    else if (dec)       cnt_d = remain;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/kwdt_bootwd.sv
module kwdt_bootwd #(
  parameter int unsigned BOOT_TICKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  output logic expire
);
  localparam int unsigned BW = (BOOT_TICKS > 1) ? $clog2(BOOT_TICKS) : 1;
  localparam logic [BW-1:0] LAST = BW'(BOOT_TICKS - 1);

  logic [BW-1:0] cnt_q, cnt_d;

  assign expire = tick && en && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!en)        cnt_d = '0;
    else if (tick)  cnt_d = expire ? '0 : cnt_q + BW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/kwdt_rstgen.sv
module kwdt_rstgen #(
  parameter int unsigned RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic to_pin,
  output logic sys_rst_req,
  output logic ext_rst_n
);
  localparam int unsigned HW = $clog2(RST_CYCLES + 1);

  logic [HW-1:0] hold_q, hold_d;
  logic          active;

  always_comb begin
    hold_d = hold_q;
    if (trig)                hold_d = HW'(RST_CYCLES);
    else if (hold_q != '0)   hold_d = hold_q - HW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign active      = (hold_q != '0);
  assign sys_rst_req = active && !to_pin;
  assign ext_rst_n   = !(active && to_pin);
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int unsigned TOUT_W     = 8,
  parameter int unsigned BOOT_TICKS = 32,
  parameter int unsigned RST_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_2hz,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        sys_rst_req,
  output logic        ext_rst_n,
  output logic        irq
);
  localparam int unsigned CNT_W = TOUT_W + 1;

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  // write decode
  logic wr_ctrl, wr_svc, wr_irqc, wr_boot;
  assign wr_ctrl = bus_wr && (bus_addr == REG_CTRL);
  assign wr_svc  = bus_wr && (bus_addr == REG_SVC);
  assign wr_irqc = bus_wr && (bus_addr == REG_IRQC);
  assign wr_boot = bus_wr && (bus_addr == REG_BOOT);

  logic [TOUT_W-1:0] wr_field;
  assign wr_field = bus_wdata[FIELD_LSB +: TOUT_W];

  // register state
  logic              run_q, run_d;
  logic              pin_q, pin_d;
  logic [TOUT_W-1:0] tout_q, tout_d;
  logic              irq_en_q, irq_en_d;
  logic [TOUT_W-1:0] lead_q, lead_d;
  logic              irq_pend_q, irq_pend_d;
  logic              boot_en_q, boot_en_d;

  logic             svc_pulse, run_rise, load, main_exp, lead_hit, boot_exp;
  logic [CNT_W-1:0] load_val, cnt;

  assign run_rise = wr_ctrl && bus_wdata[0] && !run_q;
  assign load     = svc_pulse || run_rise;
  assign load_val = run_rise ? ({1'b0, wr_field} + CNT_W'(1))
                             : ({1'b0, tout_q} + CNT_W'(1));

  always_comb begin
    run_d      = run_q | (wr_ctrl & bus_wdata[0]);
    pin_d      = pin_q | (wr_ctrl & bus_wdata[1]);
    tout_d     = wr_ctrl ? wr_field : tout_q;
    irq_en_d   = wr_irqc ? bus_wdata[0] : irq_en_q;
    lead_d     = wr_irqc ? wr_field : lead_q;
    boot_en_d  = boot_en_q & ~(wr_boot & ~bus_wdata[0]);
    irq_pend_d = irq_pend_q;
    if (wr_irqc && bus_wdata[1]) irq_pend_d = 1'b0;
    if (lead_hit && irq_en_q)    irq_pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      run_q      <= 1'b0;
      pin_q      <= 1'b0;
      tout_q     <= '1;
      irq_en_q   <= 1'b0;
      lead_q     <= '0;
      irq_pend_q <= 1'b0;
      boot_en_q  <= 1'b1;
    end else begin
      run_q      <= run_d;
      pin_q      <= pin_d;
      tout_q     <= tout_d;
      irq_en_q   <= irq_en_d;
      lead_q     <= lead_d;
      irq_pend_q <= irq_pend_d;
      boot_en_q  <= boot_en_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      REG_CTRL: begin
        bus_rdata[FIELD_LSB +: TOUT_W] = tout_q;
        bus_rdata[1:0]                 = {pin_q, run_q};
      end
      REG_IRQC: begin
        bus_rdata[FIELD_LSB +: TOUT_W] = lead_q;
        bus_rdata[1:0]                 = {irq_pend_q, irq_en_q};
      end
      REG_BOOT: bus_rdata[0] = boot_en_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = irq_pend_q;

  kwdt_keychk #(.KEY_A(KEY_FIRST), .KEY_B(KEY_SECOND)) u_key (
    .clk(clk), .rst_n(rst_sn), .wr(bus_wr), .is_svc(wr_svc),
    .wdata(bus_wdata), .svc_pulse(svc_pulse)
  );

  kwdt_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sn), .tick(tick_2hz), .run(run_q), .load(load),
    .load_val(load_val), .lead({1'b0, lead_q}), .expire(main_exp),
    .lead_hit(lead_hit), .cnt(cnt)
  );

  kwdt_bootwd #(.BOOT_TICKS(BOOT_TICKS)) u_boot (
    .clk(clk), .rst_n(rst_sn), .tick(tick_2hz), .en(boot_en_q),
    .expire(boot_exp)
  );

  kwdt_rstgen #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_sn), .trig(main_exp | boot_exp), .to_pin(pin_q),
    .sys_rst_req(sys_rst_req), .ext_rst_n(ext_rst_n)
  );
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
  parameter int unsigned CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_q,
  input logic             pin_q,
  input logic             boot_en_q,
  input logic             irq_en_q,
  input logic             svc_pulse,
  input logic [CNT_W-1:0] load_val,
  input logic [CNT_W-1:0] cnt,
  input logic             sys_rst_req,
  input logic             ext_rst_n,
  input logic             irq,
  input logic [1:0]       bus_addr,
  input logic [15:0]      bus_rdata
);
  a_r2_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> run_q);

  a_r2_pin_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pin_q |=> pin_q);

  a_r4_service_reload: assert property (@(posedge clk) disable iff (!rst_n)
    svc_pulse |=> (cnt == $past(load_val)));

  a_r6_single_path: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_rst_req && !ext_rst_n));

  a_r6_pin_routing: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_q |-> ext_rst_n);

  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(irq_en_q));

  a_r8_boot_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_en_q |=> !boot_en_q);

  a_r9_service_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd1) |-> (bus_rdata == 16'h0000));
endmodule

bind kwdt_top kwdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .pin_q(pin_q),
  .boot_en_q(boot_en_q), .irq_en_q(irq_en_q), .svc_pulse(svc_pulse),
  .load_val(load_val), .cnt(cnt), .sys_rst_req(sys_rst_req),
  .ext_rst_n(ext_rst_n), .irq(irq), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/kwdt_top_bench.sv
module kwdt_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_2hz;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        sys_rst_req, ext_rst_n, irq;

  always #5 clk = ~clk;

  kwdt_top u_kwdt_top (
    .clk(clk), .rst_n(rst_n), .tick_2hz(tick_2hz), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_rst_req(sys_rst_req), .ext_rst_n(ext_rst_n), .irq(irq)
  );

  typedef struct {
    logic [15:0] exp;
    bit          is_out;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // output vector: bit2 irq, bit1 ext_rst_n, bit0 sys_rst_req
  function automatic logic [15:0] out_vec();
    return {13'b0, irq, ext_rst_n, sys_rst_req};
  endfunction

  // monitor: pops expected items and compares with what the design shows
  initial begin
    forever begin
      wait (sb_q.size() != 0);
      begin
        sb_item_t it;
        logic [15:0] act;
        it  = sb_q.pop_front();
        act = it.is_out ? out_vec() : bus_rdata;
        n_checks++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_reg(input logic [1:0] a, input logic [15:0] e, input string tag);
    sb_item_t it;
    bus_addr = a;
    #1;
    it.exp = e; it.is_out = 1'b0; it.tag = tag;
    sb_q.push_back(it);
    #1;
  endtask

  task automatic expect_out(input logic [15:0] e, input string tag);
    sb_item_t it;
    #1;
    it.exp = e; it.is_out = 1'b1; it.tag = tag;
    sb_q.push_back(it);
    #1;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_2hz = 1'b1;
      @(negedge clk); tick_2hz = 1'b0;
    end
  endtask

  task automatic service();
    bus_write(2'd1, 16'h5555);
    bus_write(2'd1, 16'hAAAA);
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  localparam logic [15:0] IDLE = 16'h0002;
  localparam logic [15:0] SYS  = 16'h0003;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_2hz = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    expect_reg(2'd0, 16'hFF00, "R1 ctrl reset");
    expect_reg(2'd2, 16'h0000, "R1 irqc reset");
    expect_reg(2'd3, 16'h0001, "R1 boot reset");
    expect_out(IDLE, "R1 outputs idle");

    // R8 boot watchdog fires on tick 32
    ticks(31);
    expect_out(IDLE, "R8 no boot expiry at 31 ticks");
    ticks(1);
    expect_out(SYS, "R8 boot expiry at 32 ticks");
    repeat (7) @(negedge clk);
    expect_out(SYS, "R6 pulse still high in cycle 8");
    @(negedge clk);
    expect_out(IDLE, "R6 pulse ends after 8 cycles");
    bus_write(2'd3, 16'h0000);
    expect_reg(2'd3, 16'h0000, "R8 boot cleared");
    bus_write(2'd3, 16'h0001);
    expect_reg(2'd3, 16'h0000, "R8 boot cannot be re-set");
    ticks(40);
    expect_out(IDLE, "R8 no reset once boot cleared");

    // R3 enable with code 3 -> 4 ticks
    bus_write(2'd0, 16'h0301);
    expect_reg(2'd0, 16'h0301, "R3 ctrl readback");
    ticks(3);
    expect_out(IDLE, "R3 no expiry after 3 ticks");
    service();
    ticks(3);
    expect_out(IDLE, "R4 pair reloaded counter");
    ticks(1);
    expect_out(SYS, "R3 expiry after code+1 ticks, irq disabled stays 0 (R7)");
    settle();

    // R4 broken by foreign value
    ticks(3);
    bus_write(2'd1, 16'h5555);
    bus_write(2'd1, 16'h1234);
    bus_write(2'd1, 16'hAAAA);
    ticks(1);
    expect_out(SYS, "R4 broken pair does not reload");
    settle();

    // R4 broken by write to another word
    ticks(3);
    bus_write(2'd1, 16'h5555);
    bus_write(2'd2, 16'h0000);
    bus_write(2'd1, 16'hAAAA);
    ticks(1);
    expect_out(SYS, "R4 other-word write cancels pair");
    settle();

    // R2 run cannot be cleared
    bus_write(2'd0, 16'h0300);
    expect_reg(2'd0, 16'h0301, "R2 run stays set");
    ticks(3);
    expect_out(IDLE, "R2 still counting");
    ticks(1);
    expect_out(SYS, "R2 still expires after write of 0");
    settle();

    // R5 new code applies at next reload
    bus_write(2'd0, 16'h0101);
    ticks(2);
    expect_out(IDLE, "R5 old period still running");
    service();
    ticks(1);
    expect_out(IDLE, "R5 new period one tick in");
    ticks(1);
    expect_out(SYS, "R5 new period of 2 ticks");
    settle();

    // R6 / R7 external pin with lead 0
    bus_write(2'd2, 16'h0001);
    bus_write(2'd0, 16'h0103);
    expect_reg(2'd0, 16'h0103, "R2 pin route set");
    service();
    ticks(1);
    expect_out(IDLE, "R6 no early pin");
    ticks(1);
    expect_out(16'h0004, "R6 R7 pin low and irq together");
    expect_reg(2'd2, 16'h0003, "R7 pending flag read");
    bus_write(2'd0, 16'h0101);
    expect_reg(2'd0, 16'h0103, "R2 pin route stays set");
    settle();
    expect_out(16'h0006, "R7 irq held until ack");

    // R7 lead of one tick
    bus_write(2'd2, 16'h0103);
    expect_reg(2'd2, 16'h0101, "R7 ack clears pending");
    expect_out(IDLE, "R7 irq low after ack");
    service();
    ticks(1);
    expect_out(16'h0006, "R7 irq one tick ahead of expiry");
    expect_reg(2'd2, 16'h0103, "R7 pending with lead 1");
    ticks(1);
    expect_out(16'h0004, "R6 pin expiry after early irq");

    // R9
    expect_reg(2'd1, 16'h0000, "R9 service word reads zero");

    wait (sb_q.size() == 0);
    #1;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule